// File: doc/BRIEF.md
# Sampled External Interrupt Edge Detector

This block watches one asynchronous external interrupt pin and turns a chosen transition on it into a sticky interrupt request flag. The pin first passes through a synchroniser in the machine clock domain. It is then sampled either on every machine clock or once every 64 machine clocks. A level change is accepted only when two samples in a row agree. A 4-bit mode register selects which filtered transitions set the flag and how fast the pin is sampled.

The flag stays set until software clears it or the interrupt controller acknowledges it. Software may also set it directly. The request sent to the controller is the flag qualified by a per-source enable and a global master enable, and it is registered.

The block carries no data stream, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure.

Top module: `eirq_edge_detect`

## Requirements
- R1: After reset `irq_req` is 0, the mode is 0 (rising edge, machine-clock sampling) and the request flag is clear.
- R2: The pin goes through a two-flop synchroniser. A filtered level changes only when two consecutive samples agree on the new level. With machine-clock sampling, a 1-cycle pin pulse is rejected and a 2-cycle pulse is accepted.
- R3: With machine-clock sampling, enables set and a rising edge selected, suppose the pin rises before clock edge n. Then `irq_req` is still 0 after edge n+4 and is 1 after edge n+5.
- R4: Mode bits [1:0] = 00 sets the flag on a rising filtered edge only. A falling edge has no effect.
- R5: Mode bits [1:0] = 01 sets the flag on a falling filtered edge only. A rising edge has no effect.
- R6: Mode bits [1:0] = 10 sets the flag on both rising and falling filtered edges.
- R7: Mode bits [1:0] = 11 never sets the flag from the pin.
- R8: Mode bit 3 = 1 samples the pin once every 64 machine clocks, using a free-running 6-bit counter that reset clears. In this mode a pulse shorter than 64 clocks is rejected. A sustained rise does not raise `irq_req` within 60 clocks and does raise it within 140 clocks. Mode bit 3 = 0 samples on every clock. Mode bit 2 is ignored.
- R9: The flag is sticky. `flag_set` or a selected pin edge sets it, and `flag_clr` or `irq_ack` clears it. When a set and a clear happen in the same cycle, the set wins.
- R10: `irq_req` is registered as flag AND `src_en` AND `master_en`. It follows a change of any of these one clock later.
- R11: While `master_en` is 0, `irq_req` is 0 whatever the flag and `src_en` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode value: [1:0] edge select, [3] slow sampling |
| flag_set | input | 1 | Software set of the request flag |
| flag_clr | input | 1 | Software clear of the request flag |
| irq_ack | input | 1 | Controller acknowledge, clears the flag |
| src_en | input | 1 | Per-source interrupt enable |
| master_en | input | 1 | Global interrupt master enable |
| pin_async | input | 1 | Raw asynchronous interrupt pin |
| irq_req | output | 1 | Registered request to the interrupt controller |

## Verification
A single rising pin step under machine-clock sampling measures the exact latency. It also separates the synchroniser and filter depth from the output register. Pulses of one and two clocks separate the agreement filter from a plain synchroniser. Each of the four edge codes gets both a rising and a falling step, which shows whether the edge select is decoded correctly and not merely tied to any change. Under slow sampling, a short pulse and a sustained step checked at 60 and 140 clocks show that the slow strobe, and not the machine clock, gates the filter. Simultaneous set and clear, acknowledge, and toggling of each enable exercise the flag and the output gating on their own.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      slow;
    edge_sel_e edge_sel;
  } eirq_mode_t;
endpackage

// File: rtl/eirq_sampler.sv
module eirq_sampler #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_sel,
  input  logic pin_async,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       div_q;
  logic                   pin_s;
  logic                   tick;
  logic                   sample_en;
  logic                   samp_q;
  logic                   level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
  end
  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end
  assign tick      = &div_q;
  assign sample_en = slow_sel ? tick : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      level_q <= 1'b0;
    end else if (sample_en) begin
      samp_q <= pin_s;
      if (pin_s == samp_q) level_q <= pin_s;
    end
  end
  assign level = level_q;

  // R2: filtered level moves only on a sample that matched the one before
  a_r2_filter_agree: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> ($past(sample_en) && ($past(pin_s) == $past(samp_q))));

  // R8: in slow mode nothing is sampled between strobes
  a_r8_slow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel && !tick) |=> $stable(samp_q));
endmodule

// File: rtl/eirq_edge_sel.sv
module eirq_edge_sel
  import eirq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  edge_sel_e edge_sel,
  input  logic      level,
  output logic      hit
);
  logic level_d;
  logic rise;
  logic fall;

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= level;
  end

  assign rise = level & ~level_d;
  assign fall = ~level & level_d;

  always_comb begin
    unique case (edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // R7: the ignore code never reports an edge
  a_r7_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_NONE) |-> !hit);
endmodule

// File: rtl/eirq_flag_gate.sv
module eirq_flag_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic ack,
  input  logic src_en,
  input  logic master_en,
  output logic flag,
  output logic req
);
  logic flag_q;
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              flag_q <= 1'b0;
    else if (hit || sw_set)  flag_q <= 1'b1;
    else if (sw_clr || ack)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= flag_q & src_en & master_en;
  end

  assign flag = flag_q;
  assign req  = req_q;

  // R9: a set beats a clear in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || sw_set) |=> flag_q);

  // R9: a lone clear drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_clr || ack) && !hit && !sw_set) |=> !flag_q);

  // R9: flag is sticky without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !sw_clr && !ack) |=> flag_q);

  // R11: master disable blocks the request on the next clock
  a_r11_master: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !req_q);

  // R10: a request only rises after flag and source enable were both set
  a_r10_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(flag_q && src_en));
endmodule

// File: rtl/eirq_edge_detect.sv
module eirq_edge_detect
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [3:0] mode_wdata,
  input  logic       flag_set,
  input  logic       flag_clr,
  input  logic       irq_ack,
  input  logic       src_en,
  input  logic       master_en,
  input  logic       pin_async,
  output logic       irq_req
);
  eirq_mode_t mode_q;
  logic       level;
  logic       hit;
  logic       flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_we) begin
      mode_q.slow     <= mode_wdata[3];
      mode_q.edge_sel <= edge_sel_e'(mode_wdata[1:0]);
    end
  end

  eirq_sampler #(.SYNC_STAGES(SYNC_STAGES), .DIV_W(DIV_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .slow_sel(mode_q.slow),
    .pin_async(pin_async), .level(level)
  );

  eirq_edge_sel u_edge (
    .clk(clk), .rst_n(rst_n), .edge_sel(mode_q.edge_sel),
    .level(level), .hit(hit)
  );

  eirq_flag_gate u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .sw_set(flag_set),
    .sw_clr(flag_clr), .ack(irq_ack), .src_en(src_en),
    .master_en(master_en), .flag(flag), .req(irq_req)
  );

  // R1: reset leaves the mode at zero
  a_r1_reset_mode: assert property (@(posedge clk)
    $past(!rst_n) && !rst_n |=> (mode_q == '0));

  // R9: flag only appears after a pin edge or a software set
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit || flag_set));
endmodule

// File: tb/sim_eirq_edge_detect.sv
module sim_eirq_edge_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [3:0] mode_wdata = 4'd0;
  logic       flag_set = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq_ack = 1'b0;
  logic       src_en = 1'b0;
  logic       master_en = 1'b0;
  logic       pin_async = 1'b0;
  logic       irq_req;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  eirq_edge_detect u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .flag_set(flag_set), .flag_clr(flag_clr), .irq_ack(irq_ack),
    .src_en(src_en), .master_en(master_en), .pin_async(pin_async),
    .irq_req(irq_req)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (irq_req !== it.exp) begin
        n_fail++;
        $display("FAIL %s: irq_req got %0b expected %0b", it.tag, irq_req, it.exp);
      end
    end
  end

  // driver side: expectation for irq_req right after the next rising edge
  task automatic chk(input logic exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
    cyc(4);
  endtask

  task automatic clr_flag;
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic drive_pin(input logic v);
    @(negedge clk); pin_async = v;
  endtask

  initial begin
    cyc(4);
    @(negedge clk); rst_n = 1'b1;
    chk(1'b0, "R1 reset request low");
    @(negedge clk); src_en = 1'b1; master_en = 1'b1;
    chk(1'b0, "R1 flag clear after reset");

    // R3 / R4: rising edge latency in reset mode
    drive_pin(1'b1);
    cyc(4);
    chk(1'b0, "R3 not yet after n+4");
    chk(1'b1, "R3 set after n+5 (R4 rising)");
    clr_flag();
    chk(1'b0, "R9 clear drops request");
    drive_pin(1'b0); cyc(10);
    chk(1'b0, "R4 falling ignored in rising mode");

    // R2: glitch filter
    drive_pin(1'b1); drive_pin(1'b0); cyc(10);
    chk(1'b0, "R2 one-cycle pulse rejected");
    drive_pin(1'b1); @(negedge clk); drive_pin(1'b0); cyc(10);
    chk(1'b1, "R2 two-cycle pulse accepted");
    clr_flag(); cyc(2);

    // R5: falling
    set_mode(4'b0001);
    drive_pin(1'b1); cyc(10);
    chk(1'b0, "R5 rising ignored in falling mode");
    drive_pin(1'b0); cyc(10);
    chk(1'b1, "R5 falling sets flag");
    clr_flag(); cyc(2);

    // R6: both
    set_mode(4'b0010);
    drive_pin(1'b1); cyc(10);
    chk(1'b1, "R6 rising in both mode");
    clr_flag(); cyc(2);
    chk(1'b0, "R6 cleared between edges");
    drive_pin(1'b0); cyc(10);
    chk(1'b1, "R6 falling in both mode");
    clr_flag(); cyc(2);

    // R7: ignore code
    set_mode(4'b0011);
    drive_pin(1'b1); cyc(10);
    drive_pin(1'b0); cyc(10);
    chk(1'b0, "R7 ignore code never sets flag");

    // R9: set wins over same-cycle clear, then ack clears
    @(negedge clk); flag_set = 1'b1; flag_clr = 1'b1;
    @(negedge clk); flag_set = 1'b0; flag_clr = 1'b0;
    chk(1'b1, "R9 set wins over clear");
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(1'b0, "R9 acknowledge clears flag");

    // R10 / R11: gating
    @(negedge clk); flag_set = 1'b1; master_en = 1'b0;
    @(negedge clk); flag_set = 1'b0;
    cyc(2);
    chk(1'b0, "R11 master disable blocks request");
    @(negedge clk); master_en = 1'b1;
    chk(1'b1, "R10 request one clock after master enable");
    @(negedge clk); src_en = 1'b0;
    chk(1'b0, "R10 source disable drops request");
    @(negedge clk); src_en = 1'b1;
    chk(1'b1, "R10 source enable restores request");
    @(negedge clk); master_en = 1'b0;
    chk(1'b0, "R11 master off drops request");
    @(negedge clk); master_en = 1'b1;
    clr_flag(); cyc(2);

    // R8: slow sampling, rising edge (bit 2 set to show it is ignored)
    set_mode(4'b1100);
    drive_pin(1'b1);
    repeat (9) @(negedge clk);
    pin_async = 1'b0;
    cyc(200);
    chk(1'b0, "R8 short pulse rejected in slow mode");
    drive_pin(1'b1);
    cyc(59);
    chk(1'b0, "R8 slow mode not detected by 60 clocks");
    cyc(79);
    chk(1'b1, "R8 slow mode detected by 140 clocks");

    cyc(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule